// File: doc/BRIEF.md
# UART Receive Control-Character Filter

This block sits behind the character assembly stage of a UART receiver. Each assembled character arrives with a one-cycle strobe. The block compares the character against a small table of control characters that software programs. The table is searched in order of index, and the first valid entry that matches decides what happens. An entry set to accept passes the character into the receive buffer stream and closes the buffer at once, so the next character starts a new message. An entry set to reject keeps the character out of the data stream. The character goes into a holding register instead and raises an event that can be masked, which suits flow-control characters such as XOFF. A character that matches no entry is written to the buffer as plain data.

Software programs the table entries, a comparison mask, an interrupt enable and a clear register through a simple write port. It drains the holding register with a read strobe. The event flag and the overrun flag are sticky. Software clears each of them by writing 1 to its bit.

Top module: `ctrlCharFilter`

## Requirements
- R1: The table has 8 entries at config addresses 0 to 7. Each entry is 16 bits: the character in bits [7:0], the reject flag in bit 14 and the valid flag in bit 15. An entry whose valid flag is clear never matches. After reset every entry is clear.
- R2: When several valid entries match, the entry with the lowest index decides the action.
- R3: A match on an accept entry (bit 14 clear) drives bufWrEn high with the character on bufWrData. bufClose is high in the same cycle. Both appear in the cycle after the strobe.
- R4: A match on a reject entry (bit 14 set) leaves bufWrEn low. The character is loaded into holdChar, and holdFull and evtFlag are set, all in the cycle after the strobe.
- R5: A character that matches no entry is written in the cycle after its strobe, with bufClose low and no change to evtFlag. bufWrEn is never high unless a strobe came in the cycle before.
- R6: The mask at address 8 (bits [7:0]) applies to the comparison bit by bit. A 0 bit makes that character bit a don't-care. The mask resets to all ones, which gives an exact match.
- R7: irq is high exactly when evtFlag is set and the enable (address 9, bit 0) is set. evtFlag stays set until a write with bit 0 set to address 10.
- R8: A rejected character that arrives while holdFull is set, without holdRead in the same cycle, overwrites holdChar and sets overrun. overrun is cleared by a write with bit 1 set to address 10. holdRead clears holdFull.
- R9: After reset bufWrEn, bufClose, holdFull, evtFlag, overrun and irq are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxValid | input | 1 | Strobe for a received character |
| rxData | input | 8 | Received character |
| cfgWrEn | input | 1 | Config write strobe |
| cfgAddr | input | 4 | Config address (0-7 table, 8 mask, 9 enable, 10 clear) |
| cfgWrData | input | 16 | Config write data |
| holdRead | input | 1 | Software has read the holding register |
| bufWrEn | output | 1 | Buffer write strobe |
| bufWrData | output | 8 | Character written to the buffer |
| bufClose | output | 1 | Close the current buffer |
| holdChar | output | 8 | Last rejected control character |
| holdFull | output | 1 | Holding register holds an unread character |
| evtFlag | output | 1 | Sticky event for a rejected character |
| overrun | output | 1 | Sticky flag: a rejected character was overwritten |
| irq | output | 1 | Interrupt request |

## Verification
Several kinds of character are sent. Plain data shows that unmatched characters pass straight through. A character stored in an invalid entry shows that the valid flag gates the match. An accept character shows that the write and the close land together. One character matches both a low-index reject entry and a higher-index accept entry, which shows the search order. A character is sent twice, under an exact mask and then under a partial mask, so the result shows the mask at work. Two rejected characters sent back to back, and then sent again after a holdRead, tell an overrun apart from a clean capture.

// File: rtl/ccf_pkg.sv
package ccf_pkg;
  localparam int ENTRY_W   = 16;
  localparam int VALID_BIT = 15;
  localparam int REJ_BIT   = 14;

  typedef struct packed {
    logic bufWr;
    logic bufClose;
    logic capture;
  } ccfStrobes_t;
endpackage

// File: rtl/ccfDatapath.sv
module ccfDatapath
  import ccf_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_W      = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgWrEn,
  input  logic [ADDR_W-1:0]      cfgAddr,
  input  logic [ENTRY_W-1:0]     cfgWrData,
  input  logic [DATA_W-1:0]      rxData,
  input  ccfStrobes_t            strb,
  output logic [NUM_ENTRIES-1:0] hitVec,
  output logic [NUM_ENTRIES-1:0] rejVec,
  output logic                   bufWrEn,
  output logic [DATA_W-1:0]      bufWrData,
  output logic                   bufClose,
  output logic [DATA_W-1:0]      holdChar
);
  localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(NUM_ENTRIES);

  logic [DATA_W-1:0] maskQ;
  logic              unusedBits;
  assign unusedBits = ^cfgWrData[REJ_BIT-1:DATA_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) maskQ <= '1;
    else if (cfgWrEn && cfgAddr == MASK_ADDR) maskQ <= cfgWrData[DATA_W-1:0];
  end

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : gEntry
    logic              validQ;
    logic              rejQ;
    logic [DATA_W-1:0] charQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validQ <= 1'b0;
        rejQ   <= 1'b0;
        charQ  <= '0;
      end else if (cfgWrEn && cfgAddr == ADDR_W'(g)) begin
        validQ <= cfgWrData[VALID_BIT];
        rejQ   <= cfgWrData[REJ_BIT];
        charQ  <= cfgWrData[DATA_W-1:0];
      end
    end
    assign hitVec[g] = validQ && (((charQ ^ rxData) & maskQ) == '0);
    assign rejVec[g] = rejQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufWrEn   <= 1'b0;
      bufClose  <= 1'b0;
      bufWrData <= '0;
      holdChar  <= '0;
    end else begin
      bufWrEn  <= strb.bufWr;
      bufClose <= strb.bufClose;
      if (strb.bufWr)   bufWrData <= rxData;
      if (strb.capture) holdChar  <= rxData;
    end
  end
endmodule

// File: rtl/ccfCtrl.sv
module ccfCtrl
  import ccf_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_W      = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   rxValid,
  input  logic [NUM_ENTRIES-1:0] hitVec,
  input  logic [NUM_ENTRIES-1:0] rejVec,
  input  logic                   cfgWrEn,
  input  logic [ADDR_W-1:0]      cfgAddr,
  input  logic [1:0]             cfgBits,
  input  logic                   holdRead,
  output ccfStrobes_t            strb,
  output logic                   holdFull,
  output logic                   evtFlag,
  output logic                   overrun,
  output logic                   irq
);
  localparam logic [ADDR_W-1:0] EN_ADDR  = ADDR_W'(NUM_ENTRIES + 1);
  localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(NUM_ENTRIES + 2);

  logic found, isRej, intEn;

  always_comb begin
    found = 1'b0;
    isRej = 1'b0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (!found && hitVec[i]) begin
        found = 1'b1;
        isRej = rejVec[i];
      end
    end
    strb.bufWr    = rxValid && !(found && isRej);
    strb.bufClose = rxValid && found && !isRej;
    strb.capture  = rxValid && found && isRej;
  end

  logic clrEvt, clrOvr;
  assign clrEvt = cfgWrEn && cfgAddr == CLR_ADDR && cfgBits[0];
  assign clrOvr = cfgWrEn && cfgAddr == CLR_ADDR && cfgBits[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intEn    <= 1'b0;
      holdFull <= 1'b0;
      evtFlag  <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      if (cfgWrEn && cfgAddr == EN_ADDR) intEn <= cfgBits[0];
      if (strb.capture)  holdFull <= 1'b1;
      else if (holdRead) holdFull <= 1'b0;
      if (strb.capture)  evtFlag <= 1'b1;
      else if (clrEvt)   evtFlag <= 1'b0;
      if (strb.capture && holdFull && !holdRead) overrun <= 1'b1;
      else if (clrOvr)                           overrun <= 1'b0;
    end
  end

  assign irq = evtFlag && intEn;
endmodule

// File: rtl/ctrlCharFilter.sv
module ctrlCharFilter
  import ccf_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int NUM_ENTRIES = 8,
  parameter int ADDR_W      = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rxValid,
  input  logic [DATA_W-1:0]  rxData,
  input  logic               cfgWrEn,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [ENTRY_W-1:0] cfgWrData,
  input  logic               holdRead,
  output logic               bufWrEn,
  output logic [DATA_W-1:0]  bufWrData,
  output logic               bufClose,
  output logic [DATA_W-1:0]  holdChar,
  output logic               holdFull,
  output logic               evtFlag,
  output logic               overrun,
  output logic               irq
);
  ccfStrobes_t            strb;
  logic [NUM_ENTRIES-1:0] hitVec, rejVec;

  ccfDatapath #(.DATA_W(DATA_W), .NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W)) i_dp (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .rxData(rxData), .strb(strb),
    .hitVec(hitVec), .rejVec(rejVec), .bufWrEn(bufWrEn),
    .bufWrData(bufWrData), .bufClose(bufClose), .holdChar(holdChar)
  );

  ccfCtrl #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .hitVec(hitVec),
    .rejVec(rejVec), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgBits(cfgWrData[1:0]), .holdRead(holdRead), .strb(strb),
    .holdFull(holdFull), .evtFlag(evtFlag), .overrun(overrun), .irq(irq)
  );
endmodule

// File: rtl/ccfChecker.sv
module ccfChecker #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              rxValid,
  input logic              cfgWrEn,
  input logic [ADDR_W-1:0] cfgAddr,
  input logic [15:0]       cfgWrData,
  input logic              holdRead,
  input logic              bufWrEn,
  input logic              bufClose,
  input logic [DATA_W-1:0] holdChar,
  input logic              holdFull,
  input logic              evtFlag,
  input logic              overrun
);
  logic clrWr;
  assign clrWr = cfgWrEn && cfgAddr == ADDR_W'(10);

  // R3
  close_with_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    bufClose |-> bufWrEn);

  // R5
  no_spurious_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |=> !bufWrEn);

  // R4
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |=> $stable(holdChar));

  // R7
  evt_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtFlag && !(clrWr && cfgWrData[0])) |=> evtFlag);

  // R8
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !(clrWr && cfgWrData[1])) |=> overrun);

  // R8
  ovr_needs_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(holdFull));
endmodule

bind ctrlCharFilter ccfChecker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rstN(rstN), .rxValid(rxValid), .cfgWrEn(cfgWrEn),
  .cfgAddr(cfgAddr), .cfgWrData(cfgWrData), .holdRead(holdRead),
  .bufWrEn(bufWrEn), .bufClose(bufClose), .holdChar(holdChar),
  .holdFull(holdFull), .evtFlag(evtFlag), .overrun(overrun)
);

// File: tb/test_ctrlCharFilter.sv
module test_ctrlCharFilter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxValid = 1'b0;
  logic [7:0]  rxData = '0;
  logic        cfgWrEn = 1'b0;
  logic [3:0]  cfgAddr = '0;
  logic [15:0] cfgWrData = '0;
  logic        holdRead = 1'b0;
  logic        bufWrEn, bufClose, holdFull, evtFlag, overrun, irq;
  logic [7:0]  bufWrData, holdChar;

  int nTests = 0;
  int nFail  = 0;
  bit finished = 0;

  typedef struct {
    logic       wr;
    logic       close;
    logic [7:0] data;
    string      req;
  } expItem_t;
  expItem_t expQ[$];
  logic rxSeen = 1'b0;

  always #4 clk = ~clk;

  ctrlCharFilter i_ctrlCharFilter (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .holdRead(holdRead), .bufWrEn(bufWrEn), .bufWrData(bufWrData),
    .bufClose(bufClose), .holdChar(holdChar), .holdFull(holdFull),
    .evtFlag(evtFlag), .overrun(overrun), .irq(irq)
  );

  always @(posedge clk) rxSeen <= rxValid;

  // monitor: compare buffer stream against the scoreboard
  always @(negedge clk) begin
    if (rstN && rxSeen) begin
      nTests++;
      if (expQ.size() == 0) begin
        nFail++;
        $display("FAIL scoreboard empty: wr=%0b close=%0b", bufWrEn, bufClose);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        if (bufWrEn !== e.wr || bufClose !== e.close || (e.wr && bufWrData !== e.data)) begin
          nFail++;
          $display("FAIL %s: wr=%0b close=%0b data=%02h expected wr=%0b close=%0b data=%02h",
                   e.req, bufWrEn, bufClose, bufWrData, e.wr, e.close, e.data);
        end
      end
    end else if (rstN && bufWrEn) begin
      nTests++; nFail++;
      $display("FAIL R5: bufWrEn=1 without strobe, expected 0");
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic sendChar(input logic [7:0] d, input logic wr, input logic cl, input string req);
    expItem_t e;
    @(negedge clk);
    e.wr = wr; e.close = cl; e.data = d; e.req = req;
    expQ.push_back(e);
    rxValid = 1'b1; rxData = d;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9 bufWrEn", {7'b0, bufWrEn}, 8'h00);
    check("R9 bufClose", {7'b0, bufClose}, 8'h00);
    check("R9 holdFull", {7'b0, holdFull}, 8'h00);
    check("R9 evtFlag", {7'b0, evtFlag}, 8'h00);
    check("R9 overrun", {7'b0, overrun}, 8'h00);
    check("R9 irq", {7'b0, irq}, 8'h00);

    // R1 empty table after reset: everything passes as data
    sendChar(8'h0D, 1'b1, 1'b0, "R1 empty table");

    cfgWrite(4'd0, 16'h800D);   // accept CR
    cfgWrite(4'd1, 16'hC013);   // reject XOFF
    cfgWrite(4'd2, 16'h4041);   // not valid
    cfgWrite(4'd3, 16'h8013);   // accept XOFF, shadowed
    cfgWrite(4'd4, 16'hC030);   // reject '0'

    sendChar(8'h41, 1'b1, 1'b0, "R1 invalid entry");
    sendChar(8'h55, 1'b1, 1'b0, "R5 plain data");
    check("R5 evtFlag", {7'b0, evtFlag}, 8'h00);
    sendChar(8'h0D, 1'b1, 1'b1, "R3 accept closes");
    sendChar(8'h13, 1'b0, 1'b0, "R2 lowest index rejects");
    check("R4 holdChar", holdChar, 8'h13);
    check("R4 holdFull", {7'b0, holdFull}, 8'h01);
    check("R4 evtFlag", {7'b0, evtFlag}, 8'h01);
    check("R7 irq masked", {7'b0, irq}, 8'h00);
    cfgWrite(4'd9, 16'h0001);
    check("R7 irq enabled", {7'b0, irq}, 8'h01);

    sendChar(8'h35, 1'b1, 1'b0, "R6 exact mask");
    cfgWrite(4'd8, 16'h00F0);
    sendChar(8'h35, 1'b0, 1'b0, "R6 partial mask rejects");
    check("R8 overwrite", holdChar, 8'h35);
    check("R8 overrun set", {7'b0, overrun}, 8'h01);

    cfgWrite(4'd10, 16'h0001);
    check("R7 evt cleared", {7'b0, evtFlag}, 8'h00);
    check("R7 irq cleared", {7'b0, irq}, 8'h00);
    check("R8 overrun kept", {7'b0, overrun}, 8'h01);
    cfgWrite(4'd10, 16'h0002);
    check("R8 overrun cleared", {7'b0, overrun}, 8'h00);

    @(negedge clk); holdRead = 1'b1;
    @(negedge clk); holdRead = 1'b0;
    check("R8 holdRead empties", {7'b0, holdFull}, 8'h00);
    sendChar(8'h3A, 1'b0, 1'b0, "R8 clean capture");
    check("R8 no overrun", {7'b0, overrun}, 8'h00);
    check("R4 holdChar new", holdChar, 8'h3A);
    check("R7 irq again", {7'b0, irq}, 8'h01);

    cfgWrite(4'd8, 16'h00FF);
    sendChar(8'h3A, 1'b1, 1'b0, "R6 mask restored");
    repeat (3) @(negedge clk);
    check("R5 queue drained", 8'(expQ.size()), 8'h00);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule